// File: doc/BRIEF.md
# Streaming Header Traffic Classifier

This block watches Ethernet frames that arrive as a stream of 32-bit big-endian words, one word per beat, framed by start and end markers. While the frame streams past, it captures the EtherType, the IPv4 version and header length nibbles and the IPv4 protocol byte. It then locates the transport destination port, whose position moves with the IP header length. Every header test is evaluated at the same time and the results are ANDed into a single category.

Each frame produces exactly one result pulse carrying a 3-bit category: web, telnet, mail, ICMP or other. The pulse comes one cycle after the beat that carries the destination port. If the frame ends before that beat, or its headers are not valid IPv4, the pulse comes one cycle after the last beat. The block sits beside a receive path as a passive observer. It never stalls the stream and it does not buffer data.

Top module: `hdr_traffic_cls`

## Requirements
- R1: While reset is applied and after it is released, `res_valid` is low until a frame produces a result.
- R2: A frame is treated as IPv4 only when bits 31:16 of word 3 (frame bytes 12 and 13) equal 16'h0800. Any other value gives category other.
- R3: The version nibble (word 3, bits 15:12) must equal 4 and the header length nibble (word 3, bits 11:8) must be at least 5. Otherwise the category is other.
- R4: The protocol byte (word 5, bits 7:0) must equal 6 (TCP) for web, telnet or mail. A value of 1 (ICMP) gives category ICMP, and any other protocol gives other.
- R5: For TCP, destination port 80 gives web, 23 gives telnet and 25 gives mail. Any other port gives other, and UDP (17) to port 80 also gives other.
- R6: The destination port is read at byte offset 16 + 4×(header length nibble). This is word index 4 + nibble, bits 31:16, so a 20-byte header puts it in word 9 and a 60-byte header puts it in word 19.
- R7: When the headers are valid IPv4, `res_valid` pulses for one cycle in the cycle after the port beat is accepted. No second pulse follows at the end of that frame.
- R8: A frame that ends before its port beat, or whose headers fail R2 or R3, gets exactly one pulse of category other, in the cycle after its end beat.
- R9: Category codes on `res_class` are: 0 other, 1 web, 2 telnet, 3 mail, 4 ICMP. No other value appears while `res_valid` is high.
- R10: Cycles with `in_valid` low are ignored and may fall anywhere inside a frame. Valid beats that arrive outside a frame (no start marker seen) produce no result.
- R11: A start marker arriving before the previous frame ended abandons that frame without a result and restarts parsing at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A data word is present this cycle |
| in_sof | input | 1 | Current word is the first of a frame |
| in_eof | input | 1 | Current word is the last of a frame |
| in_data | input | 32 | Frame word, first byte in bits 31:24 |
| res_valid | output | 1 | One-cycle result strobe, once per frame |
| res_class | output | 3 | Category code, meaningful while `res_valid` is high |

## Verification
A wrong beat counter moves the port sample to another word. That shows up as a wrong category, or as a pulse one or more cycles away from the expected cycle, within the same frame. A stale "result owed" flag shows up as a missing pulse or a second pulse at the end beat, seen one cycle after that beat. Captured header fields that go wrong turn known web, telnet, mail or ICMP frames into other, visible on the single pulse of that frame. The bench therefore checks the pulse count, the code and the exact cycle for every frame shape.

// File: rtl/hdr_cls_pkg.sv
package hdr_cls_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_WEB    = 3'd1,
    CLS_TELNET = 3'd2,
    CLS_MAIL   = 3'd3,
    CLS_ICMP   = 3'd4
  } cls_e;

  localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
  localparam logic [7:0]  PROTO_TCP   = 8'd6;
  localparam logic [7:0]  PROTO_ICMP  = 8'd1;
  localparam logic [15:0] PORT_WEB    = 16'd80;
  localparam logic [15:0] PORT_TELNET = 16'd23;
  localparam logic [15:0] PORT_MAIL   = 16'd25;

  // big-endian byte lane: lane 0 is bits 31:24
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input int unsigned lane);
    return w[31-8*lane -: 8];
  endfunction

endpackage

// File: rtl/hdr_rst_sync.sv
module hdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/hdr_capture.sv
module hdr_capture
  import hdr_cls_pkg::*;
#(
  parameter int L2_BYTES = 14,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [31:0]      in_data,
  input  logic             emit,
  output logic             beat_live,
  output logic [IDX_W-1:0] beat_idx,
  output logic             owed,
  output logic [15:0]      etype_q,
  output logic [7:0]       vi_q,
  output logic [7:0]       proto_q
);
  localparam int ET_BYTE = L2_BYTES - 2;
  localparam int ET_WORD = ET_BYTE / 4;
  localparam int ET_LANE = ET_BYTE % 4;
  localparam int VI_WORD = L2_BYTES / 4;
  localparam int VI_LANE = L2_BYTES % 4;
  localparam int PR_BYTE = L2_BYTES + 9;
  localparam int PR_WORD = PR_BYTE / 4;
  localparam int PR_LANE = PR_BYTE % 4;
  localparam logic [IDX_W-1:0] CNT_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             owed_q, owed_d;
  logic [15:0]      etype_d;
  logic [7:0]       vi_d, proto_d;

  assign beat_live = in_valid && (in_sof || open_q);
  assign beat_idx  = in_sof ? '0 : cnt_q;
  assign owed      = in_sof ? 1'b1 : owed_q;

  always_comb begin
    cnt_d   = cnt_q;
    owed_d  = owed_q;
    etype_d = etype_q;
    vi_d    = vi_q;
    proto_d = proto_q;
    open_d  = open_q;
    if (in_valid) begin
      open_d = (in_sof || open_q) && !in_eof;
    end
    if (beat_live) begin
      cnt_d  = (beat_idx == CNT_MAX) ? beat_idx : beat_idx + 1'b1;
      owed_d = owed && !emit && !in_eof;
      if (beat_idx == IDX_W'(ET_WORD))
        etype_d = {lane_byte(in_data, ET_LANE), lane_byte(in_data, ET_LANE + 1)};
      if (beat_idx == IDX_W'(VI_WORD))
        vi_d = lane_byte(in_data, VI_LANE);
      if (beat_idx == IDX_W'(PR_WORD))
        proto_d = lane_byte(in_data, PR_LANE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      open_q  <= 1'b0;
      owed_q  <= 1'b0;
      etype_q <= '0;
      vi_q    <= '0;
      proto_q <= '0;
    end else begin
      open_q <= open_d;
      if (beat_live) begin
        cnt_q   <= cnt_d;
        owed_q  <= owed_d;
        etype_q <= etype_d;
        vi_q    <= vi_d;
        proto_q <= proto_d;
      end
    end
  end

  // a start without end leaves the frame open for the next beat
  p_open_after_sof_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof) |=> open_q);

  // a stray beat outside a frame never opens one
  p_stray_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !open_q) |=> !open_q);
endmodule

// File: rtl/hdr_port_match.sv
module hdr_port_match
  import hdr_cls_pkg::*;
#(
  parameter int L2_BYTES = 14,
  parameter int IDX_W    = 5
) (
  input  logic [15:0]      etype,
  input  logic [7:0]       vi,
  input  logic [7:0]       proto,
  input  logic [31:0]      word,
  output logic             hdr_ok,
  output logic [IDX_W-1:0] port_idx,
  output cls_e             cls
);
  localparam int OFS_W = IDX_W + 2;

  logic [OFS_W-1:0] port_ofs;
  logic [15:0]      dport;
  logic             is_ip, ver_ok, len_ok, is_tcp, is_icmp;
  logic             hit_web, hit_tel, hit_mail;

  // header length in bytes = nibble * 4, already a multiple of four
  assign port_ofs = OFS_W'(L2_BYTES + 2) + OFS_W'({vi[3:0], 2'b00});
  assign port_idx = port_ofs[OFS_W-1:2];
  assign dport    = (port_ofs[1:0] >= 2'd2) ? word[15:0] : word[31:16];

  // every header test in parallel, then ANDed
  assign is_ip    = (etype == ETYPE_IPV4);
  assign ver_ok   = (vi[7:4] == 4'd4);
  assign len_ok   = (vi[3:0] >= 4'd5);
  assign is_tcp   = (proto == PROTO_TCP);
  assign is_icmp  = (proto == PROTO_ICMP);
  assign hdr_ok   = is_ip && ver_ok && len_ok;
  assign hit_web  = hdr_ok && is_tcp && (dport == PORT_WEB);
  assign hit_tel  = hdr_ok && is_tcp && (dport == PORT_TELNET);
  assign hit_mail = hdr_ok && is_tcp && (dport == PORT_MAIL);

  always_comb begin
    cls = CLS_OTHER;
    if (hit_web)               cls = CLS_WEB;
    else if (hit_tel)          cls = CLS_TELNET;
    else if (hit_mail)         cls = CLS_MAIL;
    else if (hdr_ok && is_icmp) cls = CLS_ICMP;
  end
endmodule

// File: rtl/hdr_traffic_cls.sv
module hdr_traffic_cls
  import hdr_cls_pkg::*;
#(
  parameter int L2_BYTES = 14,
  parameter int IDX_W    = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [31:0] in_data,
  output logic        res_valid,
  output logic [2:0]  res_class
);
  logic             rst_n_s;
  logic             beat_live, owed, hdr_ok;
  logic [IDX_W-1:0] beat_idx, port_idx;
  logic [15:0]      etype;
  logic [7:0]       vi, proto;
  cls_e             cls;
  logic             fire_port, fire_eof, emit;
  logic             vld_q;
  logic [2:0]       cls_q, cls_d;

  hdr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  hdr_capture #(.L2_BYTES(L2_BYTES), .IDX_W(IDX_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .emit      (emit),
    .beat_live (beat_live),
    .beat_idx  (beat_idx),
    .owed      (owed),
    .etype_q   (etype),
    .vi_q      (vi),
    .proto_q   (proto)
  );

  hdr_port_match #(.L2_BYTES(L2_BYTES), .IDX_W(IDX_W)) u_match (
    .etype    (etype),
    .vi       (vi),
    .proto    (proto),
    .word     (in_data),
    .hdr_ok   (hdr_ok),
    .port_idx (port_idx),
    .cls      (cls)
  );

  assign fire_port = beat_live && owed && hdr_ok && (beat_idx == port_idx);
  assign fire_eof  = beat_live && owed && in_eof && !fire_port;
  assign emit      = fire_port || fire_eof;
  assign cls_d     = fire_port ? cls : CLS_OTHER;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      cls_q <= CLS_OTHER;
    end else begin
      vld_q <= emit;
      if (emit) cls_q <= cls_d;
    end
  end

  assign res_valid = vld_q;
  assign res_class = cls_q;

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !in_valid |=> !res_valid);

  p_class_code_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> (res_class <= 3'd4));

  p_eof_result_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (beat_live && in_eof && owed) |=> res_valid);

  // after a pulse nothing further is owed for that frame
  p_owed_clear_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> !u_cap.owed_q);
endmodule

// File: tb/hdr_traffic_cls_tb_top.sv
module hdr_traffic_cls_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic        res_valid;
  logic [2:0]  res_class;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int pulse_cnt = 0, last_class = -1, last_cyc = -1;
  bit done = 0;

  always #4 clk = ~clk;

  hdr_traffic_cls dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .res_valid(res_valid), .res_class(res_class)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (res_valid) begin
    pulse_cnt  = pulse_cnt + 1;
    last_class = int'(res_class);
    last_cyc   = cyc;
  end

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input int i, input logic [15:0] et,
      input logic [3:0] ver, input logic [3:0] ihl, input logic [7:0] pr, input logic [15:0] dp);
    if (i == 3) return {et, ver, ihl, 8'h00};
    if (i == 5) return {16'h4000, 8'h40, pr};
    if (ihl >= 4'd5 && i == 4 + int'(ihl)) return {dp, 16'h1234};
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic run_frame(input string req, input logic [15:0] et, input logic [3:0] ver,
      input logic [3:0] ihl, input logic [7:0] pr, input logic [15:0] dp,
      input int nw, input int gap, input int expc, input bit at_port);
    int exp_cyc = -1;
    pulse_cnt = 0;
    for (int i = 0; i < nw; i++) begin
      if (i > 0) for (int g = 0; g < gap; g++) idle();
      @(posedge clk); #1;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == nw - 1);
      in_data  = mk_word(i, et, ver, ihl, pr, dp);
      if (at_port && i == 4 + int'(ihl)) exp_cyc = cyc + 1;
      if (!at_port && i == nw - 1) exp_cyc = cyc + 1;
    end
    idle();
    repeat (3) idle();
    check(pulse_cnt == 1, {req, " pulse count"}, pulse_cnt, 1);
    check(last_class == expc, {req, " class"}, last_class, expc);
    check(last_cyc == exp_cyc, {req, " timing"}, last_cyc, exp_cyc);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 check(res_valid == 0, "R1 valid low in reset", int'(res_valid), 0);
    rst_n = 1;
    repeat (5) idle();
    check(res_valid == 0 && pulse_cnt == 0, "R1 valid low after reset", pulse_cnt, 0);
  endtask

  task automatic t_stray();
    pulse_cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sof = 0; in_eof = (i == 11);
      in_data = mk_word(i, 16'h0800, 4'd4, 4'd5, 8'd6, 16'd80);
    end
    repeat (4) idle();
    check(pulse_cnt == 0, "R10 stray beats give no result", pulse_cnt, 0);
  endtask

  task automatic t_restart();
    pulse_cnt = 0;
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sof = (i == 0); in_eof = 0;
      in_data = mk_word(i, 16'h0800, 4'd4, 4'd5, 8'd1, 16'd0);
    end
    check(pulse_cnt == 0, "R11 abandoned frame no result", pulse_cnt, 0);
    run_frame("R11 restart web", 16'h0800, 4'd4, 4'd5, 8'd6, 16'd80, 12, 0, 1, 1);
  endtask

  initial begin
    t_reset();
    run_frame("R5 web",               16'h0800, 4'd4, 4'd5, 8'd6,  16'd80,  12, 0, 1, 1);
    run_frame("R5 telnet",            16'h0800, 4'd4, 4'd5, 8'd6,  16'd23,  12, 0, 2, 1);
    run_frame("R5 mail",              16'h0800, 4'd4, 4'd5, 8'd6,  16'd25,  12, 0, 3, 1);
    run_frame("R4 icmp",              16'h0800, 4'd4, 4'd5, 8'd1,  16'd80,  12, 0, 4, 1);
    run_frame("R5 tcp other port",    16'h0800, 4'd4, 4'd5, 8'd6,  16'd443, 12, 0, 0, 1);
    run_frame("R4 udp port 80",       16'h0800, 4'd4, 4'd5, 8'd17, 16'd80,  12, 0, 0, 1);
    run_frame("R2 non-IP type",       16'h86DD, 4'd4, 4'd5, 8'd6,  16'd80,  12, 0, 0, 0);
    run_frame("R3 version 6",         16'h0800, 4'd6, 4'd5, 8'd6,  16'd80,  12, 0, 0, 0);
    run_frame("R3 hdr len 4",         16'h0800, 4'd4, 4'd4, 8'd6,  16'd80,  12, 0, 0, 0);
    run_frame("R6 hdr len 7 web",     16'h0800, 4'd4, 4'd7, 8'd6,  16'd80,  14, 0, 1, 1);
    run_frame("R6 hdr len 15 telnet", 16'h0800, 4'd4, 4'd15, 8'd6, 16'd23,  22, 0, 2, 1);
    run_frame("R8 short frame",       16'h0800, 4'd4, 4'd5, 8'd6,  16'd80,  8,  0, 0, 0);
    run_frame("R7 port on last beat", 16'h0800, 4'd4, 4'd5, 8'd6,  16'd25,  10, 0, 3, 1);
    run_frame("R10 gaps mail",        16'h0800, 4'd4, 4'd6, 8'd6,  16'd25,  13, 2, 3, 1);
    run_frame("R9 icmp code",         16'h0800, 4'd4, 4'd9, 8'd1,  16'd7,   16, 1, 4, 1);
    t_stray();
    t_restart();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule